// File: doc/BRIEF.md
# Frame-Locked Pulse-Stretching Clock Regenerator

This block rebuilds a line-rate transmission clock that follows an 8 kHz frame reference. The master clock runs slightly faster than nominal. It is supplied as a tick enable at twice its rate, so each tick is half a master period. Sixteen ticks make one line-clock period, which is eight master periods. A frame counter then divides the line clock by 193 (T1-style rate) or by 256 (CEPT-style rate) to give a local 8 kHz signal.

Frequency is corrected in only one way: master half-cycles are stretched. The block never adds a tick. It compares the selected edge of the reference with the local frame boundary, and it makes one early/late decision per frame. That decision governs the frame that follows. A late decision holds the prescaler for one extra tick at two fixed points in that frame. An early decision lets the fast master clock run unaltered, so the local phase catches up. A lock flag reports whether the decisions dither around the reference edge.

A divide mode turns the correction off. In that mode an external line-rate clock enable drives the frame counter directly.

Top module: `frame_dpll`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `line_clk` is 0, `frame_out` is 1 and `locked` is 0.
- R2: In normal mode with no correction, the line-clock period is 16 ticks: low for ticks 0..7 and high for ticks 8..15. The `frame_out` period is 16·D ticks, where D is 193 when `div_sel`=0 and 256 when `div_sel`=1. `frame_out` is high during the first floor(D/2) line periods after its rising edge.
- R3: Every frame contains exactly D rising edges of `line_clk`, whether or not that frame is stretched.
- R4: The selected reference edge sets the frame's phase decision. If the edge arrives while `frame_out` is high (first half of the local frame), the decision is late. If it arrives while `frame_out` is low, the decision is early. When several selected edges fall in one frame, the last one counts. The decision takes effect at the next local frame boundary and is kept through frames with no selected edge. Each frame that runs under a late decision is exactly 2 ticks longer: one extra tick at line period 0 and one at line period floor(D/2).
- R5: When `edge_sel`=0 only rising edges of `ref_in` are compared, and when `edge_sel`=1 only falling edges are. The other edge has no effect on the decision.
- R6: `locked` rises at the frame boundary that completes 8 consecutive decisions, each one differing from the decision before it.
- R7: `locked` falls at the frame boundary that completes 8 consecutive decisions, each one equal to the decision before it.
- R8: While `divide_mode`=1, the following hold:
  - `ext_tick` advances the frame counter, so the `frame_out` period is D `ext_tick` pulses.
  - `line_clk` stays 0.
  - `locked` is 0.
  - Reference edges are ignored.
  - The decision is cleared to early, so frames after leaving divide mode start unstretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Master half-period tick (2x master clock enable) |
| ext_tick | input | 1 | External line-rate clock enable used in divide mode |
| ref_in | input | 1 | 8 kHz frame reference |
| edge_sel | input | 1 | 0 = lock to rising edge, 1 = lock to falling edge |
| div_sel | input | 1 | 0 = divide by 193, 1 = divide by 256 |
| divide_mode | input | 1 | 1 = bypass correction and divide ext_tick |
| line_clk | output | 1 | Regenerated line-rate clock |
| frame_out | output | 1 | Local 8 kHz signal, rising at each frame boundary |
| locked | output | 1 | Phase decisions dithering around the reference |

## Verification
The hardest condition to reach from the ports is a long, controlled run of phase decisions. Lock needs eight alternating decisions, and loss of lock needs eight equal ones, while stretching keeps shifting the frame boundary. The stimulus reacts to each observed `frame_out` rise and places a single selected reference edge a fixed number of cycles into that frame, early or late as the scenario demands. A separate step drives an edge of the wrong polarity at a position that would have flipped a held late decision, then checks that the next frame is still 2 ticks long.

// File: rtl/frame_dpll_pkg.sv
package frame_dpll_pkg;

  typedef enum logic {
    PH_EARLY = 1'b0,
    PH_LATE  = 1'b1
  } phase_e;

  // position of the second stretch slot inside a frame of d line periods
  function automatic int unsigned half_of(input int unsigned d);
    return d / 2;
  endfunction

  // edge of interest on a sampled pair: pol=0 rising, pol=1 falling
  function automatic logic pick_edge(input logic pol, input logic prev, input logic cur);
    return pol ? (prev & ~cur) : (~prev & cur);
  endfunction

endpackage

// File: rtl/fdpll_prescaler.sv
module fdpll_prescaler #(
  parameter int unsigned TICKS = 16,
  localparam int unsigned PW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          hold_zero,
  input  logic          stretch_req,
  output logic [PW-1:0] pre_cnt,
  output logic          carry,
  output logic          line_clk,
  output logic          stall
);

  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);
  localparam logic [PW-1:0] MID  = PW'(TICKS / 2);

  logic stalled_q;
  logic adv;

  assign stall    = tick_en && stretch_req && !stalled_q && !hold_zero;
  assign adv      = tick_en && !stall && !hold_zero;
  assign carry    = adv && (pre_cnt == LAST);
  assign line_clk = (pre_cnt >= MID);

  always_ff @(posedge clk) begin
    if (rst || hold_zero) begin
      pre_cnt   <= '0;
      stalled_q <= 1'b0;
    end else if (stall) begin
      stalled_q <= 1'b1;
    end else if (adv) begin
      pre_cnt   <= carry ? '0 : pre_cnt + 1'b1;
      stalled_q <= 1'b0;
    end
  end

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pre_cnt)); // R4
  AST_IDLE_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !hold_zero) |=> $stable(pre_cnt)); // R2
  AST_NO_DOUBLE_STALL: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R4

endmodule

// File: rtl/fdpll_frame_div.sv
module fdpll_frame_div
  import frame_dpll_pkg::*;
#(
  parameter int unsigned DIV_A = 193,
  parameter int unsigned DIV_B = 256,
  parameter int unsigned FW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          div_sel,
  output logic [FW-1:0] frame_cnt,
  output logic          wrap,
  output logic          frame_out,
  output logic          slot_pos
);

  localparam logic [FW-1:0] LAST_A = FW'(DIV_A - 1);
  localparam logic [FW-1:0] LAST_B = FW'(DIV_B - 1);
  localparam logic [FW-1:0] HALF_A = FW'(half_of(DIV_A));
  localparam logic [FW-1:0] HALF_B = FW'(half_of(DIV_B));
  localparam int unsigned   CMAX   = (DIV_A > DIV_B) ? DIV_A : DIV_B;

  logic [FW-1:0] last_c;
  logic [FW-1:0] half_c;

  assign last_c    = div_sel ? LAST_B : LAST_A;
  assign half_c    = div_sel ? HALF_B : HALF_A;
  assign wrap      = adv && (frame_cnt >= last_c);
  assign frame_out = (frame_cnt < half_c);
  assign slot_pos  = (frame_cnt == '0) || (frame_cnt == half_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
    end else if (adv) begin
      frame_cnt <= wrap ? '0 : frame_cnt + 1'b1;
    end
  end

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame_cnt < FW'(CMAX)); // R2
  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (frame_cnt == '0) && frame_out); // R2

endmodule

// File: rtl/fdpll_phase_det.sv
module fdpll_phase_det
  import frame_dpll_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clear,
  input  logic   ref_in,
  input  logic   edge_sel,
  input  logic   first_half,
  input  logic   wrap,
  output phase_e decision,
  output logic   upd,
  output logic   changed
);

  logic   ref_q;
  logic   seen_q;
  phase_e pend_q;
  logic   sel_edge;
  logic   seen_n;
  phase_e pend_n;

  assign sel_edge = pick_edge(edge_sel, ref_q, ref_in);
  assign seen_n   = seen_q | sel_edge;
  assign pend_n   = sel_edge ? (first_half ? PH_LATE : PH_EARLY) : pend_q;
  assign upd      = wrap && seen_n && !clear;
  assign changed  = (pend_n != decision);

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_q   <= 1'b0;
      pend_q   <= PH_EARLY;
      decision <= PH_EARLY;
    end else if (wrap) begin
      seen_q <= 1'b0;
      if (seen_n) decision <= pend_n;
    end else begin
      seen_q <= seen_n;
      pend_q <= pend_n;
    end
  end

  AST_DECISION_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !clear) |=> $stable(decision)); // R4
  AST_CLEAR_TO_EARLY: assert property (@(posedge clk) disable iff (rst)
    clear |=> (decision == PH_EARLY)); // R8

endmodule

// File: rtl/fdpll_lock_mon.sv
module fdpll_lock_mon #(
  parameter int unsigned LOCK_RUN = 8,
  localparam int unsigned LW = $clog2(LOCK_RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic upd,
  input  logic changed,
  output logic locked
);

  localparam logic [LW-1:0] RUN = LW'(LOCK_RUN);

  logic [LW-1:0] alt_q;
  logic [LW-1:0] same_q;
  logic [LW-1:0] alt_n;
  logic [LW-1:0] same_n;

  assign alt_n  = (alt_q  == RUN) ? alt_q  : alt_q  + 1'b1;
  assign same_n = (same_q == RUN) ? same_q : same_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      alt_q  <= '0;
      same_q <= '0;
      locked <= 1'b0;
    end else if (upd) begin
      if (changed) begin
        alt_q  <= alt_n;
        same_q <= '0;
        if (alt_n == RUN) locked <= 1'b1;
      end else begin
        same_q <= same_n;
        alt_q  <= '0;
        if (same_n == RUN) locked <= 1'b0;
      end
    end
  end

  AST_LOCK_ONLY_ON_DECISION: assert property (@(posedge clk) disable iff (rst)
    (!upd && !clear) |=> $stable(locked)); // R6
  AST_LOCK_RISES_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(changed)); // R6
  AST_LOCK_FALLS_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(!changed) || $past(clear))); // R7

endmodule

// File: rtl/frame_dpll.sv
module frame_dpll
  import frame_dpll_pkg::*;
#(
  parameter int unsigned DIV_T1   = 193,
  parameter int unsigned DIV_CEPT = 256,
  parameter int unsigned PRE_DIV  = 8,
  parameter int unsigned LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic ext_tick,
  input  logic ref_in,
  input  logic edge_sel,
  input  logic div_sel,
  input  logic divide_mode,
  output logic line_clk,
  output logic frame_out,
  output logic locked
);

  localparam int unsigned PRE_TICKS = 2 * PRE_DIV;
  localparam int unsigned PW        = $clog2(PRE_TICKS);
  localparam int unsigned DIV_MAX   = (DIV_T1 > DIV_CEPT) ? DIV_T1 : DIV_CEPT;
  localparam int unsigned FW        = $clog2(DIV_MAX + 1);

  logic [PW-1:0] pre_cnt;
  logic          pre_carry;
  logic          stall;
  logic          stretch_req;
  logic [FW-1:0] frame_cnt;
  logic          frame_adv;
  logic          frame_wrap;
  logic          slot_pos;
  phase_e        decision;
  logic          dec_upd;
  logic          dec_changed;

  // a stretch slot is the first tick of line period 0 or of the half point
  assign stretch_req = (decision == PH_LATE) && slot_pos && (pre_cnt == '0);
  assign frame_adv   = divide_mode ? ext_tick : pre_carry;

  fdpll_prescaler #(.TICKS(PRE_TICKS)) u_pre (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .hold_zero   (divide_mode),
    .stretch_req (stretch_req),
    .pre_cnt     (pre_cnt),
    .carry       (pre_carry),
    .line_clk    (line_clk),
    .stall       (stall)
  );

  fdpll_frame_div #(.DIV_A(DIV_T1), .DIV_B(DIV_CEPT), .FW(FW)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .adv       (frame_adv),
    .div_sel   (div_sel),
    .frame_cnt (frame_cnt),
    .wrap      (frame_wrap),
    .frame_out (frame_out),
    .slot_pos  (slot_pos)
  );

  fdpll_phase_det u_phase (
    .clk        (clk),
    .rst        (rst),
    .clear      (divide_mode),
    .ref_in     (ref_in),
    .edge_sel   (edge_sel),
    .first_half (frame_out),
    .wrap       (frame_wrap),
    .decision   (decision),
    .upd        (dec_upd),
    .changed    (dec_changed)
  );

  fdpll_lock_mon #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .clear   (divide_mode),
    .upd     (dec_upd),
    .changed (dec_changed),
    .locked  (locked)
  );

  AST_DIVIDE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    divide_mode |=> !line_clk); // R8
  AST_DIVIDE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    divide_mode |=> !locked); // R8
  AST_STALL_NEEDS_LATE: assert property (@(posedge clk) disable iff (rst)
    stall |-> (decision == PH_LATE) && !divide_mode); // R4
  AST_FRAME_FOLLOWS_PRESCALER: assert property (@(posedge clk) disable iff (rst)
    (!divide_mode && !pre_carry) |=> $stable(frame_cnt)); // R3

endmodule

// File: tb/frame_dpll_tb_top.sv
`timescale 1ns/1ps
module frame_dpll_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, tick_en, ext_tick, ref_in, edge_sel, div_sel, divide_mode;
  wire  line_clk, frame_out, locked;

  frame_dpll dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_tick(ext_tick),
    .ref_in(ref_in), .edge_sel(edge_sel), .div_sel(div_sel),
    .divide_mode(divide_mode), .line_clk(line_clk),
    .frame_out(frame_out), .locked(locked)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tick_div = 2;
  int ext_div = 3;
  int tcnt = 0;
  int ecnt = 0;

  int    q_per[$];
  int    q_lck[$];
  string q_tag[$];
  event  frame_ev;

  bit m_dec = 0;
  int m_alt = 0;
  int m_same = 0;
  bit m_lock = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick sources
  initial begin
    tick_en = 1'b0;
    ext_tick = 1'b0;
    forever begin
      @(negedge clk);
      tick_en  = (tcnt == 0);
      tcnt     = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
      ext_tick = (ecnt == 0);
      ecnt     = (ecnt + 1 >= ext_div) ? 0 : ecnt + 1;
    end
  end

  // monitor: measures each frame and pops the expected item
  initial begin
    longint cyc = 0;
    longint last = 0;
    bit have_last = 0;
    bit prev_f = 1'b1;
    bit prev_l = 1'b0;
    int lcnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (line_clk && !prev_l) lcnt++;
      if (frame_out && !prev_f) begin
        if (have_last && q_per.size() > 0) begin
          int ep, el;
          string et;
          ep = q_per.pop_front();
          el = q_lck.pop_front();
          et = q_tag.pop_front();
          chk((cyc - last) == ep, et, cyc - last, ep);
          chk(lcnt == el, "R3 line edges per frame", lcnt, el);
        end
        last = cyc;
        have_last = 1;
        lcnt = 0;
        -> frame_ev;
      end
      prev_f = frame_out;
      prev_l = line_clk;
    end
  end

  function automatic void model_decide(input bit late);
    if (divide_mode) return;
    if (late != m_dec) begin
      m_alt  = (m_alt < 8) ? m_alt + 1 : 8;
      m_same = 0;
      if (m_alt >= 8) m_lock = 1;
    end else begin
      m_same = (m_same < 8) ? m_same + 1 : 8;
      m_alt  = 0;
      if (m_same >= 8) m_lock = 0;
    end
    m_dec = late;
  endfunction

  task automatic flush();
    q_per.delete();
    q_lck.delete();
    q_tag.delete();
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 none, 1 late pulse, 2 early pulse, 3 late selected edge only,
  //       4 early opposite edge only
  task automatic run_frame(input int kind, input string tag, input string lock_tag);
    int d, per, lck, late_d, early_d, flen;
    bit idle;
    @(frame_ev);
    d = div_sel ? 256 : 193;
    if (divide_mode) begin
      per = ext_div * d;
      lck = 0;
    end else begin
      per = (16 * d + (m_dec ? 2 : 0)) * tick_div;
      lck = d;
    end
    q_per.push_back(per);
    q_lck.push_back(lck);
    q_tag.push_back(tag);
    wait_cyc(4);
    if (lock_tag != "") chk(locked == m_lock, lock_tag, locked, m_lock);
    flen = divide_mode ? ext_div * d : 16 * d * tick_div;
    late_d = flen / 30;
    early_d = (flen * 3) / 4;
    idle = edge_sel;
    case (kind)
      1: begin wait_cyc(late_d);  ref_in = ~idle; wait_cyc(40); ref_in = idle; model_decide(1); end
      2: begin wait_cyc(early_d); ref_in = ~idle; wait_cyc(40); ref_in = idle; model_decide(0); end
      3: begin wait_cyc(late_d);  ref_in = ~idle; model_decide(1); end
      4: begin wait_cyc(early_d); ref_in = idle; end
      default: ;
    endcase
  endtask

  initial begin
    rst = 1'b1; ref_in = 1'b0; edge_sel = 1'b0; div_sel = 1'b0; divide_mode = 1'b0;
    wait_cyc(5);
    chk(line_clk == 1'b0, "R1 line_clk in reset", line_clk, 0);
    chk(frame_out == 1'b1, "R1 frame_out in reset", frame_out, 1);
    chk(locked == 1'b0, "R1 locked in reset", locked, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(line_clk == 1'b0 && frame_out == 1'b1 && locked == 1'b0, "R1 after release",
        {line_clk, frame_out, locked}, 3'b010);

    // R2: free running, tick every second cycle, then every cycle
    run_frame(0, "R2 period 193 half-rate tick", "R1");
    run_frame(0, "R2 period 193 half-rate tick", "");
    tick_div = 1;
    flush();
    run_frame(0, "R2 period 193", "");
    run_frame(0, "R2 period 193", "");

    // R4: late edge stretches following frames, early edge releases
    run_frame(1, "R4 frame with late edge", "");
    run_frame(0, "R4 stretched after late", "");
    run_frame(0, "R4 decision held without edge", "");
    run_frame(2, "R4 still stretched in early frame", "");
    run_frame(0, "R4 unstretched after early", "");

    // R6: alternate decisions until lock
    for (int i = 0; i < 9; i++) begin
      run_frame((i % 2 == 0) ? 1 : 2, "R4 period during alternation", "R6 lock on alternation");
    end
    // R7: repeated late decisions drop lock
    for (int i = 0; i < 9; i++) begin
      run_frame(1, "R4 period during repeated late", "R7 unlock on repeat");
    end
    run_frame(0, "R4 period", "R7 unlock on repeat");

    // R5: falling edge selected, rising ignored
    edge_sel = 1'b1;
    ref_in = 1'b1;
    run_frame(2, "R5 falling early pulse", "");
    run_frame(3, "R5 falling late edge", "");
    run_frame(4, "R5 stretched, rising edge only", "");
    run_frame(0, "R5 rising edge ignored, still stretched", "");
    run_frame(2, "R5 stretched", "");
    run_frame(0, "R5 released by falling early", "");

    // R2/R4 with divisor 256
    div_sel = 1'b1;
    flush();
    run_frame(0, "R2 period 256", "");
    run_frame(1, "R2 period 256 with late edge", "");
    run_frame(2, "R4 stretched 256", "");
    run_frame(0, "R4 unstretched 256", "");

    // R8: divide mode
    divide_mode = 1'b1;
    flush();
    wait_cyc(3);
    chk(line_clk == 1'b0, "R8 line_clk low in divide", line_clk, 0);
    chk(locked == 1'b0, "R8 unlocked in divide", locked, 0);
    m_dec = 0; m_alt = 0; m_same = 0; m_lock = 0;
    run_frame(1, "R8 divide period", "R8");
    run_frame(1, "R8 divide period, edges ignored", "R8");
    run_frame(1, "R8 divide period, edges ignored", "R8");
    run_frame(0, "R8 divide period", "R8");
    divide_mode = 1'b0;
    flush();
    run_frame(0, "R8 after divide", "");
    run_frame(0, "R8 decision cleared by divide", "R8");
    @(frame_ev);
    wait_cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule